// File: doc/BRIEF.md
# I2C Transmit Master with NACK Stall

This block is a single-master I2C write controller. Software loads data bytes into a small transmit FIFO and programs a target address, a byte count and a clock prescaler through a narrow write-only register port. It then raises the start and stop requests. The block drives a START condition and the 7-bit address with the write bit clear. It then sends the programmed number of data bytes from the FIFO and closes the transfer with a STOP. Both bus lines are open-drain: the block only ever pulls a line low, and it reads the shared SDA line back to sample the acknowledge bit.

A not-acknowledge does not end the transfer on its own. After a NACK on any byte, the block drops the pending stop request and raises a sticky NACK flag. It keeps SCL pulled low with SDA released, and the bus stays marked busy and owned. It remains in that state until software writes the stop request again. The same parked state is used when the count runs out before any stop has been requested. An empty FIFO partway through a counted transfer also holds SCL low, until a byte is written.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset both line drives are released, and the start request, stop request, NACK, busy and master flags are 0. The FIFO is empty and enabled. The prescaler holds PRESC_RESET.
- R2: Writing 1 to bit 0 of the control register (address 0) while idle sets the start request. The block then pulls SDA low with SCL released for one phase and pulls SCL low. The start request clears itself as SCL goes low. Busy and master read 1 from the START until the STOP completes.
- R3: The first byte is {address register (address 2) bits 6:0, 0}, followed by count register (address 1) data bytes in FIFO write order. All bytes go MSB first. SDA only changes while SCL is low, so exactly one START appears per transfer.
- R4: The acknowledge is sampled on the ninth SCL clock at the end of its high phase. A high level is a NACK, and this applies to the address byte too.
- R5: When all counted bytes are acknowledged and bit 1 of the control register was set, the STOP sequence runs: SDA is pulled low while SCL is low, SCL is released, and SDA is released one phase later. Busy, master and the stop request then read 0.
- R6: On a NACK the stop request clears and the NACK flag sets. SCL stays pulled low, SDA is released, and busy and master stay 1.
- R7: While parked, either after a NACK or after the count runs out with no stop request, no STOP occurs. A STOP follows only once bit 1 of the control register is written with 1.
- R8: The NACK flag holds until a write with bit 0 set to status-clear (address 4). A write with bit 0 clear leaves it set.
- R9: A start request written while busy is dropped: the start request stays 0.
- R10: If the FIFO is empty when a counted byte is due, SCL stays low until a byte is written. The transfer then continues.
- R11: Bit 2 of the control register enables the FIFO. While it is 0 the FIFO is emptied and writes to the data port (address 3) are dropped. Clearing and setting it again discards queued bytes.
- R12: Each SCL low and high phase lasts PRESC+1 clocks. PRESC is the prescaler register (address 5), and its valid values are 1 to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| start_req | output | 1 | Pending start request |
| stop_req | output | 1 | Pending stop request |
| nack_flag | output | 1 | Sticky not-acknowledge status |
| bus_busy | output | 1 | Bus held between START and STOP |
| master_act | output | 1 | Block owns the bus as master |
| fifo_level | output | $clog2(FIFO_DEPTH+1) | Bytes queued in the transmit FIFO |

## Verification
The assertions check on every cycle that SDA stays steady through each SCL high phase of a bit. They also check that the bus is released only straight after an SDA-low, SCL-high cycle, and that a NACK lands in the parked state with the stop request gone. The remaining cycle-by-cycle checks cover the sticky NACK flag, the dropped start request while busy, and the FIFO bound. The bench scenarios show the end-to-end behaviour: byte order on the wire, the address-phase and data-phase NACK parks, the STOP that appears only after the stop request is rewritten, the underflow hold, the flush, and the phase length at two prescaler settings.

// File: rtl/i2c_tx_master.sv
module i2c_tx_master #(
  parameter int FIFO_DEPTH  = 4,
  parameter int PRESC_RESET = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             reg_we,
  input  logic [2:0]                       reg_addr,
  input  logic [7:0]                       reg_wdata,
  input  logic                             sda_i,
  output logic                             scl_oe,
  output logic                             sda_oe,
  output logic                             start_req,
  output logic                             stop_req,
  output logic                             nack_flag,
  output logic                             bus_busy,
  output logic                             master_act,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]  fifo_level
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int LVL_W = $clog2(FIFO_DEPTH+1);
  localparam logic [2:0] A_CTRL = 3'd0, A_COUNT = 3'd1, A_SADDR = 3'd2,
                         A_TXD = 3'd3, A_CLR = 3'd4, A_PRESC = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_LOW, S_HIGH, S_WAIT, S_PARK, S_STOP_A, S_STOP_B
  } state_t;

  state_t             state;
  logic [7:0]         div_cnt, presc, count, left, shreg;
  logic [6:0]         saddr;
  logic [3:0]         bitcnt;
  logic               fifo_en, sda_q;
  logic [7:0]         mem [FIFO_DEPTH];
  logic [PTR_W-1:0]   wp, rp;
  logic [LVL_W-1:0]   lvl;

  wire tick      = (div_cnt == presc);
  wire ack_tick  = (state == S_HIGH) && tick && (bitcnt == 4'd8);
  wire have_data = fifo_en && (lvl != '0);
  wire push      = reg_we && (reg_addr == A_TXD) && fifo_en && (lvl != LVL_W'(FIFO_DEPTH));
  wire pop       = (ack_tick && !sda_i && (left != 8'd0) && have_data) ||
                   ((state == S_WAIT) && have_data);

  assign scl_oe     = (state == S_LOW) || (state == S_WAIT) ||
                      (state == S_PARK) || (state == S_STOP_A);
  assign sda_oe     = sda_q;
  assign bus_busy   = (state != S_IDLE);
  assign master_act = (state != S_IDLE);
  assign fifo_level = lvl;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; lvl <= '0;
    end else if (!fifo_en) begin
      wp <= '0; rp <= '0; lvl <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      lvl <= lvl + LVL_W'(push) - LVL_W'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_q <= 1'b0;
    else begin
      case (state)
        S_START, S_STOP_A, S_STOP_B: sda_q <= 1'b1;
        S_LOW:                       sda_q <= (bitcnt != 4'd8) && !shreg[7];
        S_HIGH:                      sda_q <= sda_q;
        default:                     sda_q <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; div_cnt <= '0; presc <= 8'(PRESC_RESET);
      count <= '0; left <= '0; shreg <= '0; saddr <= '0; bitcnt <= '0;
      start_req <= 1'b0; stop_req <= 1'b0; nack_flag <= 1'b0; fifo_en <= 1'b1;
    end else begin
      div_cnt <= tick ? 8'd0 : div_cnt + 8'd1;

      if (reg_we) begin
        case (reg_addr)
          A_CTRL: begin
            if (reg_wdata[0] && state == S_IDLE) start_req <= 1'b1;
            if (reg_wdata[1]) stop_req <= 1'b1;
            fifo_en <= reg_wdata[2];
          end
          A_COUNT: count <= reg_wdata;
          A_SADDR: saddr <= reg_wdata[6:0];
          A_CLR:   if (reg_wdata[0]) nack_flag <= 1'b0;
          A_PRESC: presc <= reg_wdata;
          default: ;
        endcase
      end

      case (state)
        S_IDLE: if (start_req) begin
          state <= S_START; div_cnt <= '0;
        end
        S_START: if (tick) begin
          start_req <= 1'b0;
          shreg     <= {saddr, 1'b0};
          bitcnt    <= '0;
          left      <= count;
          state     <= S_LOW;
        end
        S_LOW: if (tick) state <= S_HIGH;
        S_HIGH: if (tick) begin
          if (bitcnt != 4'd8) begin
            bitcnt <= bitcnt + 4'd1;
            shreg  <= {shreg[6:0], 1'b0};
            state  <= S_LOW;
          end else if (sda_i) begin
            nack_flag <= 1'b1;
            stop_req  <= 1'b0;
            state     <= S_PARK;
          end else if (left == 8'd0) begin
            state <= stop_req ? S_STOP_A : S_PARK;
          end else if (have_data) begin
            shreg  <= mem[rp];
            left   <= left - 8'd1;
            bitcnt <= '0;
            state  <= S_LOW;
          end else begin
            state <= S_WAIT;
          end
        end
        S_WAIT: if (have_data) begin
          shreg   <= mem[rp];
          left    <= left - 8'd1;
          bitcnt  <= '0;
          div_cnt <= '0;
          state   <= S_LOW;
        end
        S_PARK: if (stop_req) begin
          div_cnt <= '0;
          state   <= S_STOP_A;
        end
        S_STOP_A: if (tick) state <= S_STOP_B;
        S_STOP_B: if (tick) begin
          stop_req <= 1'b0;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: the start request drops only as the START hands over to a pulled-low SCL
  p_start_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_req) |-> (bus_busy && scl_oe));

  // R3: data on SDA is steady for the whole SCL high phase of a bit
  p_sda_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HIGH && $past(state) == S_HIGH) |-> $stable(sda_oe));

  // R5: the bus is freed only right after SDA low with SCL released
  p_stop_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |-> $past(!scl_oe && sda_oe));

  // R6: a fresh NACK leaves SCL pulled low, SDA released, stop request gone
  p_nack_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_flag) |-> (scl_oe && !sda_oe && bus_busy && master_act && !stop_req));

  // R8: NACK holds until the clear write
  p_nack_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_flag && !(reg_we && reg_addr == A_CLR && reg_wdata[0])) |=> nack_flag);

  // R9: a start write while busy leaves the request clear
  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CTRL && reg_wdata[0] && bus_busy && !start_req) |=> !start_req);

  // R11: the FIFO level never exceeds its depth
  p_fifo_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LVL_W'(FIFO_DEPTH));
endmodule

// File: tb/i2c_tx_master_tb.sv
`timescale 1ns/1ps
module i2c_tx_master_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic scl_oe, sda_oe, start_req, stop_req, nack_flag, bus_busy, master_act;
  logic [2:0] fifo_level;
  logic slv_low = 1'b0;
  wire scl = !scl_oe;
  wire sda = !(sda_oe || slv_low);

  int checks = 0, errors = 0;
  int starts = 0, stops = 0, byte_idx = 0, nack_idx = -1, bitn = 0;
  bit in_xfer = 1'b0;
  logic [7:0] sh = '0;
  logic [7:0] exp_q[$];
  realtime t_rise = 0.0, last_per = 0.0;

  always #2.5 clk = ~clk;

  i2c_tx_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sda_i(sda), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .start_req(start_req), .stop_req(stop_req), .nack_flag(nack_flag),
    .bus_busy(bus_busy), .master_act(master_act), .fifo_level(fifo_level)
  );

  // Monitor and slave model
  always @(negedge sda) if (scl === 1'b1 && rst_n === 1'b1) begin
    in_xfer = 1'b1; bitn = 0; byte_idx = 0; starts++;
  end
  always @(posedge sda) if (scl === 1'b1 && rst_n === 1'b1) begin
    in_xfer = 1'b0; stops++;
  end
  always @(posedge scl) if (in_xfer) begin
    if (bitn < 8) begin
      if (bitn > 0) last_per = $realtime - t_rise;
      t_rise = $realtime;
      sh = {sh[6:0], sda};
      bitn++;
      if (bitn == 8) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R3 unexpected byte: actual=%0h expected=none", sh);
        end else begin
          automatic logic [7:0] e = exp_q.pop_front();
          if (sh !== e) begin
            errors++;
            $display("FAIL R3 byte on wire: actual=%0h expected=%0h", sh, e);
          end
        end
      end
    end else begin
      bitn = 0;
      byte_idx++;
    end
  end
  always @(negedge scl) begin
    if (in_xfer && bitn == 8) slv_low = (byte_idx != nack_idx);
    else slv_low = 1'b0;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_free();
    for (int i = 0; i < 5000 && bus_busy; i++) @(negedge clk);
  endtask

  task automatic wait_nack();
    for (int i = 0; i < 5000 && !nack_flag; i++) @(negedge clk);
  endtask

  initial begin
    int s0, t0;
    idle(3); rst_n = 1'b1; idle(2);
    // R1 reset state
    chk("R1", "scl_oe", scl_oe, 0);
    chk("R1", "sda_oe", sda_oe, 0);
    chk("R1", "flags", {start_req, stop_req, nack_flag, bus_busy, master_act}, 0);
    chk("R1", "fifo_level", fifo_level, 0);

    // Plain transfer: two data bytes, start and stop back to back
    wr(5, 8'd4); wr(2, 8'h50); wr(1, 8'd2); wr(3, 8'hA5); wr(3, 8'h3C);
    chk("R11", "level after two pushes", fifo_level, 2);
    exp_q.push_back(8'hA0); exp_q.push_back(8'hA5); exp_q.push_back(8'h3C);
    s0 = stops; t0 = starts;
    wr(0, 8'h05); wr(0, 8'h06);
    idle(20);
    chk("R2", "start_req self-clears", start_req, 0);
    chk("R2", "busy and master", {bus_busy, master_act}, 2'b11);
    wr(0, 8'h05);
    chk("R9", "start while busy dropped", start_req, 0);
    wait_free(); idle(4);
    chk("R5", "one STOP", stops - s0, 1);
    chk("R3", "one START", starts - t0, 1);
    chk("R5", "stop_req cleared", stop_req, 0);
    chk("R5", "lines released", {scl_oe, sda_oe}, 0);
    chk("R3", "all bytes sent", exp_q.size(), 0);
    chk("R12", "bit period presc=4", int'(last_per), 50);

    // NACK on the second data byte
    wr(2, 8'h2A); wr(1, 8'd3); wr(3, 8'h11); wr(3, 8'h22); wr(3, 8'h33);
    exp_q.push_back(8'h54); exp_q.push_back(8'h11); exp_q.push_back(8'h22);
    nack_idx = 2; s0 = stops;
    wr(0, 8'h05); wr(0, 8'h06);
    wait_nack(); idle(60);
    chk("R6", "SCL held low", scl_oe, 1);
    chk("R6", "SDA released", {sda_oe, sda}, 2'b01);
    chk("R6", "busy and master", {bus_busy, master_act}, 2'b11);
    chk("R6", "stop_req cleared", stop_req, 0);
    chk("R7", "no STOP while parked", stops - s0, 0);
    chk("R11", "unsent byte still queued", fifo_level, 1);
    wr(4, 8'h00);
    chk("R8", "flag kept on bit0=0", nack_flag, 1);
    wr(4, 8'h01);
    chk("R8", "flag cleared", nack_flag, 0);
    wr(0, 8'h00); wr(0, 8'h04);
    chk("R11", "flush", fifo_level, 0);
    idle(20);
    chk("R7", "still parked after flush", {bus_busy, scl_oe}, 2'b11);
    wr(0, 8'h06);
    wait_free(); idle(4);
    chk("R7", "STOP after stop rewrite", stops - s0, 1);
    chk("R3", "bytes up to NACK", exp_q.size(), 0);
    nack_idx = -1;

    // NACK on the address byte, fast prescaler
    wr(5, 8'd1); wr(2, 8'h11); wr(1, 8'd1); wr(3, 8'h77);
    exp_q.push_back(8'h22);
    nack_idx = 0; s0 = stops;
    wr(0, 8'h05); wr(0, 8'h06);
    wait_nack(); idle(30);
    chk("R4", "address NACK flagged", nack_flag, 1);
    chk("R4", "parked after address", {bus_busy, scl_oe, stop_req}, 3'b110);
    chk("R4", "data byte not taken", fifo_level, 1);
    chk("R12", "bit period presc=1", int'(last_per), 20);
    wr(4, 8'h01); wr(0, 8'h00); wr(0, 8'h04); wr(0, 8'h06);
    wait_free(); idle(4);
    chk("R7", "STOP after address NACK", stops - s0, 1);
    chk("R3", "only address sent", exp_q.size(), 0);
    nack_idx = -1;

    // FIFO underflow mid-transfer
    wr(5, 8'd4); wr(2, 8'h33); wr(1, 8'd2); wr(3, 8'h5A);
    exp_q.push_back(8'h66); exp_q.push_back(8'h5A); exp_q.push_back(8'hC3);
    s0 = stops;
    wr(0, 8'h05); wr(0, 8'h06);
    idle(400);
    chk("R10", "SCL held on underflow", {bus_busy, scl_oe}, 2'b11);
    chk("R10", "no STOP yet", stops - s0, 0);
    chk("R10", "no NACK", nack_flag, 0);
    wr(3, 8'hC3);
    wait_free(); idle(4);
    chk("R10", "completes after refill", stops - s0, 1);
    chk("R10", "bytes after refill", exp_q.size(), 0);

    // Count runs out with no stop request
    wr(2, 8'h7F); wr(1, 8'd1); wr(3, 8'h81);
    exp_q.push_back(8'hFE); exp_q.push_back(8'h81);
    s0 = stops;
    wr(0, 8'h05);
    idle(400);
    chk("R7", "parked without stop", {bus_busy, scl_oe, sda_oe}, 3'b110);
    chk("R7", "no STOP without request", stops - s0, 0);
    wr(0, 8'h06);
    wait_free(); idle(4);
    chk("R5", "STOP after late request", stops - s0, 1);
    chk("R3", "parked transfer bytes", exp_q.size(), 0);

    // Writes while FIFO disabled are dropped
    wr(0, 8'h00); wr(3, 8'h99);
    chk("R11", "write dropped while disabled", fifo_level, 0);
    wr(0, 8'h04); wr(3, 8'h99);
    chk("R11", "write accepted when enabled", fifo_level, 1);
    wr(0, 8'h00); wr(0, 8'h04);
    chk("R11", "second flush", fifo_level, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule